// File: doc/BRIEF.md
# Prescaled Low-Frequency Counter with Compare Channels

This block is a real-time counter for slow timekeeping. It is driven by a slow tick strobe that is synchronous to the system clock. A prescaler divides that tick stream and advances a counter. Each advance raises a tick event. A wrap of the counter past its largest value raises an overflow event. When the counter lands on the value held in one of the compare registers, that channel raises its own compare event.

Software controls the block through single-cycle register reads and writes:

- Task registers start the counter, stop it, zero it, or move it close to its wrap point.
- Each event sets a sticky flag. Software clears a flag by writing zero to it.
- One mask decides which flags drive the interrupt line.
- A second, independent mask decides which event pulses appear on the event output pins.
- Each mask is changed through a pair of registers: one sets bits and one clears bits.

Event index `e` is used throughout: 0 is tick, 1 is overflow, and 2 to 5 are compare channels 0 to 3. Registers are word-addressed. Only bit 0 of a write matters for the task and flag registers.

Top module: `rtcu_top`

## Requirements
- R1: After reset the counter reads 0, the counter is stopped, all event flags read 0, both masks read 0, `irq` is low and `evtOut` is 0.
- R2: While running, the counter advances by one on every (P+1)-th `tickEn` cycle. P is the prescaler field, bits [11:0] of the prescaler register at address 0x0E. Reading 0x0E returns P.
- R3: The prescaler value in use is taken only while the counter is stopped. A prescaler write made while running has no effect on the counting rate until the counter is stopped and started again.
- R4: Writing 1 to address 0x00 starts the counter and writing 1 to 0x01 stops it. While stopped, `tickEn` does not change the counter.
- R5: Writing 1 to address 0x02 sets the counter and the prescale phase to zero.
- R6: Writing 1 to address 0x03 loads the counter with 0xFFFFF0. The overflow event (e=1) fires when the counter advances from 0xFFFFFF to 0.
- R7: The tick event (e=0) fires on every advance. Compare event e=2+i fires when the counter advances to the value in compare register i. Compare register i sits at address 0x10+i and holds the low 24 bits written. The counter reads at address 0x0F.
- R8: The flag for event e reads at address 0x08+e in bit 0. It sets one cycle after the event and stays set. Writing 0 to it clears it; writing 1 leaves it unchanged.
- R9: Writing to 0x04 sets the interrupt-mask bits where the data has a 1. Writing to 0x05 clears them. Bit e belongs to event e. Reading either address returns the mask.
- R10: `irq` is high exactly when some flag e is set and interrupt-mask bit e is set.
- R11: Writing to 0x06 sets routing-mask bits and writing to 0x07 clears them. Reading either address returns the routing mask. `evtOut[e]` is high for the single cycle in which event e fires, and only if routing bit e is set. The interrupt mask has no effect on `evtOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Slow tick strobe, one cycle per input tick |
| wrEn | input | 1 | Register write strobe |
| addr | input | 5 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |
| evtOut | output | 6 | Routed event pulses, bit e for event e |

## Verification
The assertions check, on every cycle:

- A tick pulse always comes with an advance by exactly one.
- An overflow pulse always comes with a count of zero.
- A compare pulse always matches the compare value that was in place before the advance.
- A clear task always leaves the count at zero.
- A stopped counter holds its value.
- Every event pulse is captured in its flag.

The prescale rate, the latching of the prescaler only while stopped, the behaviour of writes to the flag registers, the mask set/clear arithmetic, and the independence of routing from interrupt masking all depend on register sequences. Only the bench scenarios show those.

// File: rtl/rtcu_pkg.sv
package rtcu_pkg;
  localparam int EVT_TICK = 0;
  localparam int EVT_OVF  = 1;
  localparam int EVT_CMP0 = 2;

  localparam int A_START    = 0;
  localparam int A_STOP     = 1;
  localparam int A_CLEAR    = 2;
  localparam int A_FORCEOVF = 3;
  localparam int A_INTSET   = 4;
  localparam int A_INTCLR   = 5;
  localparam int A_ROUTESET = 6;
  localparam int A_ROUTECLR = 7;
  localparam int A_FLAGBASE = 8;
  localparam int A_PRESC    = 14;
  localparam int A_COUNT    = 15;
  localparam int A_CMPBASE  = 16;

  typedef struct packed {
    logic start;
    logic stop;
    logic clear;
    logic forceOvf;
  } taskStrb_t;
endpackage

// File: rtl/rtcu_ctrl.sv
module rtcu_ctrl
  import rtcu_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 12,
  parameter int NCMP   = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int NEVT  = NCMP + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [CNT_W-1:0]           count,
  input  logic [NEVT-1:0]            evtPulse,
  output logic [DATA_W-1:0]          rdData,
  output taskStrb_t                  strb,
  output logic [PRE_W-1:0]           prescReg,
  output logic [NCMP-1:0][CNT_W-1:0] cmpVal,
  output logic [NEVT-1:0]            intMask,
  output logic [NEVT-1:0]            routeMask,
  output logic [NEVT-1:0]            flags
);
  logic [NEVT-1:0] flagClr;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  // Task strobes act on the clock edge that commits the write.
  always_comb begin
    strb.start    = wrEn && hit(addr, A_START) && wrData[0];
    strb.stop     = wrEn && hit(addr, A_STOP) && wrData[0];
    strb.clear    = wrEn && hit(addr, A_CLEAR) && wrData[0];
    strb.forceOvf = wrEn && hit(addr, A_FORCEOVF) && wrData[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intMask   <= '0;
      routeMask <= '0;
      prescReg  <= '0;
    end else if (wrEn) begin
      if (hit(addr, A_INTSET))   intMask   <= intMask | wrData[NEVT-1:0];
      if (hit(addr, A_INTCLR))   intMask   <= intMask & ~wrData[NEVT-1:0];
      if (hit(addr, A_ROUTESET)) routeMask <= routeMask | wrData[NEVT-1:0];
      if (hit(addr, A_ROUTECLR)) routeMask <= routeMask & ~wrData[NEVT-1:0];
      if (hit(addr, A_PRESC))    prescReg  <= wrData[PRE_W-1:0];
    end
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rstN) cmpVal[i] <= '0;
      else if (wrEn && hit(addr, A_CMPBASE + i)) cmpVal[i] <= wrData[CNT_W-1:0];
    end
  end

  // A new event wins over a clearing write made in the same cycle.
  for (genvar e = 0; e < NEVT; e++) begin : g_flag
    assign flagClr[e] = wrEn && hit(addr, A_FLAGBASE + e) && !wrData[0];
    always_ff @(posedge clk) begin
      if (!rstN) flags[e] <= 1'b0;
      else       flags[e] <= evtPulse[e] | (flags[e] & ~flagClr[e]);
    end
  end

  always_comb begin
    rdData = '0;
    if (hit(addr, A_INTSET) || hit(addr, A_INTCLR))     rdData[NEVT-1:0] = intMask;
    if (hit(addr, A_ROUTESET) || hit(addr, A_ROUTECLR)) rdData[NEVT-1:0] = routeMask;
    if (hit(addr, A_PRESC)) rdData[PRE_W-1:0] = prescReg;
    if (hit(addr, A_COUNT)) rdData[CNT_W-1:0] = count;
    for (int e = 0; e < NEVT; e++)
      if (hit(addr, A_FLAGBASE + e)) rdData[0] = flags[e];
    for (int i = 0; i < NCMP; i++)
      if (hit(addr, A_CMPBASE + i)) rdData[CNT_W-1:0] = cmpVal[i];
  end
endmodule

// File: rtl/rtcu_datapath.sv
module rtcu_datapath
  import rtcu_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int PRE_W      = 12,
  parameter int NCMP       = 4,
  parameter int OVF_MARGIN = 16,
  localparam int NEVT      = NCMP + 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       tickEn,
  input  taskStrb_t                  strb,
  input  logic [PRE_W-1:0]           prescReg,
  input  logic [NCMP-1:0][CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0]           count,
  output logic [NEVT-1:0]            evtPulse,
  output logic                       running
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] OVF_LOAD = ALL_ONES - CNT_W'(OVF_MARGIN - 1);

  logic [PRE_W-1:0] activePresc;
  logic [PRE_W-1:0] preCnt;
  logic             preStep;
  logic             advance;
  logic [CNT_W-1:0] nextCount;
  logic [NCMP-1:0]  cmpHit;
  logic [NEVT-1:0]  evtNext;

  assign preStep   = running && tickEn;
  assign advance   = preStep && (preCnt >= activePresc);
  assign nextCount = count + CNT_W'(1);

  for (genvar i = 0; i < NCMP; i++) begin : g_match
    assign cmpHit[i] = (nextCount == cmpVal[i]);
  end

  // Task writes take priority over a tick that lands in the same cycle.
  always_comb begin
    evtNext = '0;
    if (advance && !strb.clear && !strb.forceOvf) begin
      evtNext[EVT_TICK] = 1'b1;
      evtNext[EVT_OVF]  = (count == ALL_ONES);
      evtNext[EVT_CMP0 +: NCMP] = cmpHit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running     <= 1'b0;
      activePresc <= '0;
      preCnt      <= '0;
      count       <= '0;
      evtPulse    <= '0;
    end else begin
      if (strb.stop)       running <= 1'b0;
      else if (strb.start) running <= 1'b1;
      if (!running) activePresc <= prescReg;
      if (strb.clear || strb.forceOvf) preCnt <= '0;
      else if (preStep)                preCnt <= advance ? '0 : preCnt + PRE_W'(1);
      if (strb.clear)         count <= '0;
      else if (strb.forceOvf) count <= OVF_LOAD;
      else if (advance)       count <= nextCount;
      evtPulse <= evtNext;
    end
  end
endmodule

// File: rtl/rtcu_top.sv
module rtcu_top
  import rtcu_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 12,
  parameter int NCMP   = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int NEVT  = NCMP + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic [NEVT-1:0]   evtOut
);
  taskStrb_t                  strb;
  logic [PRE_W-1:0]           prescReg;
  logic [NCMP-1:0][CNT_W-1:0] cmpVal;
  logic [NEVT-1:0]            intMask;
  logic [NEVT-1:0]            routeMask;
  logic [NEVT-1:0]            flags;
  logic [CNT_W-1:0]           count;
  logic [NEVT-1:0]            evtPulse;
  logic                       running;

  rtcu_ctrl #(.CNT_W(CNT_W), .PRE_W(PRE_W), .NCMP(NCMP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .count(count), .evtPulse(evtPulse), .rdData(rdData), .strb(strb),
    .prescReg(prescReg), .cmpVal(cmpVal), .intMask(intMask),
    .routeMask(routeMask), .flags(flags)
  );

  rtcu_datapath #(.CNT_W(CNT_W), .PRE_W(PRE_W), .NCMP(NCMP)) dp_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .strb(strb), .prescReg(prescReg),
    .cmpVal(cmpVal), .count(count), .evtPulse(evtPulse), .running(running)
  );

  assign irq    = |(flags & intMask);
  assign evtOut = evtPulse & routeMask;
endmodule

// File: rtl/rtcu_chk.sv
module rtcu_chk
  import rtcu_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int NCMP  = 4,
  localparam int NEVT = NCMP + 2
) (
  input logic                       clk,
  input logic                       rstN,
  input taskStrb_t                  strb,
  input logic                       running,
  input logic [CNT_W-1:0]           count,
  input logic [NEVT-1:0]            evtPulse,
  input logic [NEVT-1:0]            flags,
  input logic [NCMP-1:0][CNT_W-1:0] cmpVal
);
  // R7
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse[EVT_TICK] |-> count == $past(count) + CNT_W'(1));

  // R6
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse[EVT_OVF] |-> count == '0);

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> count == '0);

  // R4
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strb.clear && !strb.forceOvf) |=> $stable(count));

  for (genvar e = 0; e < NEVT; e++) begin : g_flagchk
    // R8
    flag_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[e] |=> flags[e]);
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmpchk
    // R7
    cmp_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[EVT_CMP0 + i] |-> count == $past(cmpVal[i]));
  end
endmodule

bind rtcu_top rtcu_chk #(.CNT_W(CNT_W), .NCMP(NCMP)) chk_i (
  .clk(clk), .rstN(rstN), .strb(strb), .running(running), .count(count),
  .evtPulse(evtPulse), .flags(flags), .cmpVal(cmpVal)
);

// File: tb/rtcu_top_tb_top.sv
module rtcu_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;
  logic [5:0]  evtOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  rtcu_top dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .evtOut(evtOut)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = 5'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic busRead(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 5'(a);
    #1 d = rdData;
  endtask

  task automatic tickPulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic clearFlags();
    for (int e = 0; e < 6; e++) busWrite(8 + e, 32'h0);
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(15, v); check("R1 count", v, 0);
    busRead(4, v);  check("R1 int mask", v, 0);
    busRead(6, v);  check("R1 route mask", v, 0);
    busRead(8, v);  check("R1 tick flag", v, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 evtOut", 32'(evtOut), 0);
    tickPulses(3);
    busRead(15, v); check("R1 stopped after reset", v, 0);
  endtask

  task automatic testPrescale();
    logic [31:0] v;
    busWrite(14, 32'hF003);
    busRead(14, v); check("R2 prescaler field width", v, 32'h003);
    busWrite(14, 2);
    busRead(14, v); check("R2 prescaler readback", v, 2);
    busWrite(2, 1);
    busWrite(0, 1);
    tickPulses(9);
    busRead(15, v); check("R2 count after 9 ticks, P=2", v, 3);
    busWrite(1, 1);
    tickPulses(4);
    busRead(15, v); check("R4 stopped counter holds", v, 3);
    busWrite(2, 1);
    busRead(15, v); check("R5 clear task", v, 0);
  endtask

  task automatic testLatch();
    logic [31:0] v;
    busWrite(14, 2);
    busWrite(2, 1);
    busWrite(0, 1);
    busWrite(14, 0);
    tickPulses(3);
    busRead(15, v); check("R3 running write ignored", v, 1);
    busWrite(1, 1);
    busWrite(2, 1);
    busWrite(0, 1);
    tickPulses(4);
    busRead(15, v); check("R3 new prescaler after restart", v, 4);
    busWrite(1, 1);
  endtask

  task automatic testOverflow();
    logic [31:0] v;
    busWrite(14, 0);
    busWrite(2, 1);
    clearFlags();
    busWrite(3, 1);
    busRead(15, v); check("R6 force overflow load", v, 32'hFFFFF0);
    busWrite(0, 1);
    tickPulses(15);
    busRead(15, v); check("R6 count at top", v, 32'hFFFFFF);
    busRead(9, v);  check("R6 no overflow before wrap", v, 0);
    tickPulses(1);
    busRead(15, v); check("R6 count wrapped", v, 0);
    busRead(9, v);  check("R6 overflow flag", v, 1);
    busWrite(1, 1);
  endtask

  task automatic testCompare();
    logic [31:0] v;
    busWrite(2, 1);
    busWrite(18, 32'h0100_0005);
    busRead(18, v); check("R7 compare 24-bit field", v, 5);
    clearFlags();
    busWrite(0, 1);
    tickPulses(4);
    busRead(12, v); check("R7 compare2 not yet", v, 0);
    busRead(8, v);  check("R7 tick flag", v, 1);
    tickPulses(1);
    busRead(12, v); check("R7 compare2 match", v, 1);
    busRead(10, v); check("R7 compare0 no match", v, 0);
    busWrite(1, 1);
  endtask

  task automatic testFlags();
    logic [31:0] v;
    busWrite(12, 1);
    busRead(12, v); check("R8 write 1 keeps flag", v, 1);
    busWrite(12, 0);
    busRead(12, v); check("R8 write 0 clears flag", v, 0);
    busWrite(12, 1);
    busRead(12, v); check("R8 write 1 does not set", v, 0);
  endtask

  task automatic testIrq();
    logic [31:0] v;
    #1 check("R10 irq low with mask clear", 32'(irq), 0);
    busWrite(4, 32'h01);
    #1 check("R10 irq from tick flag", 32'(irq), 1);
    busRead(4, v); check("R9 set reg readback", v, 32'h01);
    busWrite(4, 32'h10);
    busRead(5, v); check("R9 clear reg readback", v, 32'h11);
    busWrite(5, 32'h01);
    busRead(4, v); check("R9 clear one bit", v, 32'h10);
    #1 check("R10 irq low, masked flag clear", 32'(irq), 0);
    busWrite(12, 0);
    busWrite(5, 32'h3F);
    busRead(4, v); check("R9 all cleared", v, 0);
  endtask

  task automatic testRoute();
    logic [31:0] v;
    busWrite(6, 32'h01);
    busRead(7, v); check("R11 route readback", v, 32'h01);
    busWrite(2, 1);
    busWrite(0, 1);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    #1 check("R11 tick routed out", 32'(evtOut), 32'h01);
    check("R11 irq unaffected by routing", 32'(irq), 0);
    @(negedge clk);
    #1 check("R11 single-cycle pulse", 32'(evtOut), 0);
    busWrite(7, 32'h01);
    busRead(6, v); check("R11 route cleared", v, 0);
    @(negedge clk); tickEn = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    #1 check("R11 unrouted tick stays off", 32'(evtOut), 0);
    busWrite(1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPrescale();
    testLatch();
    testOverflow();
    testCompare();
    testFlags();
    testIrq();
    testRoute();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule